// File: doc/BRIEF.md
# Deep-Sleep Pin Wake-Up Detector

This block watches six wake-capable input pins while the chip sits in its deepest sleep state. Each pin has its own enable bit and its own active-level bit. Detection is level based. While the sleep indication is high, an enabled pin that is at its active level sets its bit in a sticky cause register. Any set cause bit raises the wake request. Software reads the cause register to find which pin woke the system, then clears every cause bit at once with a command bit.

A retention control bit is also provided. The block brings it out as a flag. It also drives a hold output that freezes the pad outputs for as long as both the retention bit and the sleep indication are high.

The pins first pass through a two-stage synchronizer. The detection state is tracked by a small state machine:

- States:
  - `ST_IDLE`: awake, no cause pending.
  - `ST_ARMED`: asleep, watching, no cause pending.
  - `ST_PENDING`: one or more cause bits held.
- Transitions:
  - `ARM`: IDLE to ARMED when sleep rises.
  - `DISARM`: ARMED to IDLE when sleep falls.
  - `HIT`: ARMED to PENDING when an enabled pin matches its level.
  - `CLEAR_AWAKE`: PENDING to IDLE on a clear with sleep low.
  - `CLEAR_ASLEEP`: PENDING to ARMED on a clear with sleep high and no new hit.

A clear with sleep high and a hit still present is a `HIT` again on the following edge.

Top module: `wake_detect`

## Requirements
- R1: After reset, every register reads zero, and `wake_req`, `wake_cause`, `retain_flag` and `pin_hold` are all low.
- R2: Byte offsets on the bus are:
  - 0x12C: retention control, bit 0.
  - 0x130: command register; it always reads zero.
  - 0x134: pin enable, bits 5:0.
  - 0x138: active-level select, bits 5:0.
  - 0x13C: cause, bits 5:0; read-only.

  Bits above the stored width read zero. Any other offset reads zero.
- R3: Bit i of the enable, level-select and cause registers corresponds to `wake_pin[i]`, for i from 0 to 5.
- R4: A level-select bit of 1 makes a high level wake, and 0 makes a low level wake. With sleep high, a pin change applied between edges appears in the cause register after the third rising edge: two synchronizer stages plus the latch.
- R5: A pin whose enable bit is 0 never sets its cause bit.
- R6: While `sleep_i` is low, no cause bit is set, whatever the pin levels.
- R7: Cause bits are sticky. They stay set after the pin leaves its active level and after sleep falls.
- R8: A bus write with bit 0 set at offset 0x130 clears all cause bits at that edge, even if a hit occurs in the same cycle. Writing 0 there changes nothing.
- R9: `wake_req` is high exactly when at least one cause bit is set.
- R10: `retain_flag` equals control bit 0. `pin_hold` is high exactly when that bit and `sleep_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_pin | input | 6 | Raw levels of the six wake-capable pins |
| sleep_i | input | 1 | High while the system is in deepest sleep |
| bus_addr | input | 12 | Byte offset for register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wake_req | output | 1 | Wake request, OR of the cause bits |
| wake_cause | output | 6 | Cause register contents |
| retain_flag | output | 1 | Retention control bit |
| pin_hold | output | 1 | Pad-output freeze request while sleeping |

## Verification
A table of enable, level and pin patterns is applied, which covers the following cases:

- High-active and low-active selections.
- Only the top pin enabled.
- Partly disabled sets.
- Every pin matching versus every pin mismatching.
- Sleep held low.

Taken together, these separate polarity inversion, bit-order mistakes and missing enable or sleep gating.

Directed tests then pin down the following:

- The exact three-edge detection latency.
- Stickiness across pin release and wake.
- Clear beating a simultaneous hit, followed by re-latching of a still-active level.
- A zero command write leaving the cause intact.
- The hold output tracking sleep only when retention is set.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int N_PINS    = 6;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h12C;
    localparam logic [ADDR_W-1:0] OFS_CMD   = 12'h130;
    localparam logic [ADDR_W-1:0] OFS_EN    = 12'h134;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 12'h138;
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 12'h13C;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_PENDING = 2'd2
    } wake_state_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_i;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic [N_PINS-1:0] cause_i,
    output logic [N_PINS-1:0] en_o,
    output logic [N_PINS-1:0] level_o,
    output logic              retain_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int PAD_W = DATA_W - N_PINS;

    logic [N_PINS-1:0] en_q;
    logic [N_PINS-1:0] level_q;
    logic              retain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= '0;
            level_q  <= '0;
            retain_q <= 1'b0;
        end else if (bus_we) begin
            if (bus_addr == OFS_EN)    en_q     <= bus_wdata[N_PINS-1:0];
            if (bus_addr == OFS_LEVEL) level_q  <= bus_wdata[N_PINS-1:0];
            if (bus_addr == OFS_CTRL)  retain_q <= bus_wdata[0];
        end
    end

    assign clr_o = bus_we && (bus_addr == OFS_CMD) && bus_wdata[0];

    always_comb begin
        unique case (bus_addr)
            OFS_CTRL:  bus_rdata = {{(DATA_W-1){1'b0}}, retain_q};
            OFS_EN:    bus_rdata = {{PAD_W{1'b0}}, en_q};
            OFS_LEVEL: bus_rdata = {{PAD_W{1'b0}}, level_q};
            OFS_CAUSE: bus_rdata = {{PAD_W{1'b0}}, cause_i};
            default:   bus_rdata = '0;
        endcase
    end

    assign en_o     = en_q;
    assign level_o  = level_q;
    assign retain_o = retain_q;
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic [N_PINS-1:0] pin_s_i,
    input  logic [N_PINS-1:0] en_i,
    input  logic [N_PINS-1:0] level_i,
    input  logic              clr_i,
    output logic [N_PINS-1:0] cause_o,
    output logic              wake_req_o
);
    wake_state_t       state_q, state_d;
    logic [N_PINS-1:0] cause_q, cause_d;
    logic [N_PINS-1:0] hits;

    assign hits = en_i & ~(pin_s_i ^ level_i) & {N_PINS{sleep_i}};

    // next-state and cause update
    always_comb begin
        cause_d = clr_i ? '0 : (cause_q | hits);
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cause_d != '0)  state_d = ST_PENDING;
                else if (sleep_i)   state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cause_d != '0)  state_d = ST_PENDING;
                else if (!sleep_i)  state_d = ST_IDLE;
            end
            ST_PENDING: begin
                if (cause_d == '0)  state_d = sleep_i ? ST_ARMED : ST_IDLE;
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_PENDING: wake_req_o = 1'b1;
            default:    wake_req_o = 1'b0;
        endcase
    end
    assign cause_o = cause_q;

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cause_q == '0);  // R8
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cause_q & $past(cause_q)) == $past(cause_q));  // R7
    AST_NO_DETECT_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_i && !clr_i) |=> cause_q == $past(cause_q));  // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cause_q & ~$past(cause_q) & ~$past(en_i)) == '0);  // R5
    AST_REQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o == (cause_q != '0));  // R9
endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import wake_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        wake_pin,
    input  logic              sleep_i,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              wake_req,
    output logic [5:0]        wake_cause,
    output logic              retain_flag,
    output logic              pin_hold
);
    logic [N_PINS-1:0] pin_s, en, level, cause;
    logic              retain, clr;

    wake_sync #(.WIDTH(N_PINS), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(wake_pin), .q_o(pin_s)
    );

    wake_regs u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .cause_i(cause), .en_o(en), .level_o(level),
        .retain_o(retain), .clr_o(clr), .bus_rdata(bus_rdata)
    );

    wake_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .pin_s_i(pin_s),
        .en_i(en), .level_i(level), .clr_i(clr),
        .cause_o(cause), .wake_req_o(wake_req)
    );

    assign wake_cause  = cause;
    assign retain_flag = retain;
    assign pin_hold    = retain & sleep_i;

    AST_HOLD_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hold |-> (sleep_i && retain_flag));  // R10
endmodule

// File: tb/wake_detect_bench.sv
module wake_detect_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  wake_pin = '0;
    logic        sleep_i = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        wake_req;
    logic [5:0]  wake_cause;
    logic        retain_flag;
    logic        pin_hold;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wake_detect u_wake_detect (
        .clk(clk), .rst_n(rst_n), .wake_pin(wake_pin), .sleep_i(sleep_i),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .wake_req(wake_req), .wake_cause(wake_cause),
        .retain_flag(retain_flag), .pin_hold(pin_hold)
    );

    // fields: enable[24:19], level[18:13], pins[12:7], sleep[6], expected cause[5:0]
    localparam int NV = 8;
    localparam logic [24:0] VEC [NV] = '{
        {6'h3F, 6'h3F, 6'h01, 1'b1, 6'h01},
        {6'h3F, 6'h00, 6'h3E, 1'b1, 6'h01},
        {6'h20, 6'h20, 6'h3F, 1'b1, 6'h20},
        {6'h0F, 6'h3F, 6'h3F, 1'b1, 6'h0F},
        {6'h3F, 6'h3F, 6'h3F, 1'b0, 6'h00},
        {6'h00, 6'h00, 6'h00, 1'b1, 6'h00},
        {6'h3F, 6'h2A, 6'h2A, 1'b1, 6'h3F},
        {6'h3F, 6'h2A, 6'h15, 1'b1, 6'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin : watchdog
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        rd(12'h13C, r); chk("R1 cause", r, 0);
        rd(12'h134, r); chk("R1 enable", r, 0);
        rd(12'h12C, r); chk("R1 control", r, 0);
        chk("R1 outputs", {wake_req, wake_cause, retain_flag, pin_hold}, 0);

        // R2 readback with upper bits masked
        wr(12'h134, 32'hFFFF_FFE5);
        rd(12'h134, r); chk("R2 enable readback", r, 32'h25);
        wr(12'h138, 32'h0000_001A);
        rd(12'h138, r); chk("R2 level readback", r, 32'h1A);
        wr(12'h130, 32'h0);
        rd(12'h130, r); chk("R2 command reads zero", r, 0);
        rd(12'h140, r); chk("R2 unmapped reads zero", r, 0);

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            sleep_i = 1'b0;
            wr(12'h130, 32'h1);
            wr(12'h134, {26'h0, VEC[v][24:19]});
            wr(12'h138, {26'h0, VEC[v][18:13]});
            wake_pin = VEC[v][12:7];
            cyc(3);
            sleep_i = VEC[v][6];
            cyc(2);
            rd(12'h13C, r);
            chk($sformatf("R3/R4/R5/R6 vector %0d cause", v), r, {26'h0, VEC[v][5:0]});
            chk($sformatf("R9 vector %0d request", v), {31'h0, wake_req}, {31'h0, VEC[v][5:0] != 0});
            sleep_i = 1'b0;
        end

        // R4 latency: enable pin 2 high-active, sleeping
        wr(12'h130, 32'h1);
        wr(12'h134, 32'h04);
        wr(12'h138, 32'h04);
        wake_pin = 6'h00;
        cyc(3);
        sleep_i = 1'b1;
        cyc(2);
        wake_pin = 6'h04;
        cyc(2);
        chk("R4 not yet after two edges", {26'h0, wake_cause}, 0);
        cyc(1);
        chk("R4 latched after third edge", {26'h0, wake_cause}, 32'h04);

        // R7 stickiness
        wake_pin = 6'h00;
        cyc(4);
        chk("R7 sticky after pin release", {26'h0, wake_cause}, 32'h04);
        sleep_i = 1'b0;
        cyc(2);
        chk("R7 sticky after wake", {26'h0, wake_cause}, 32'h04);

        // R8 zero write has no effect
        wr(12'h130, 32'hFFFF_FFFE);
        chk("R8 zero command keeps cause", {26'h0, wake_cause}, 32'h04);

        // R8 clear beats a simultaneous hit, then level re-latches
        wake_pin = 6'h04;
        cyc(3);
        sleep_i = 1'b1;
        cyc(1);
        wr(12'h130, 32'h1);
        chk("R8 clear wins over hit", {26'h0, wake_cause}, 0);
        chk("R9 request low after clear", {31'h0, wake_req}, 0);
        cyc(1);
        chk("R8 active level re-latches", {26'h0, wake_cause}, 32'h04);
        chk("R9 request high", {31'h0, wake_req}, 1);

        // R10 retention and hold
        sleep_i = 1'b0;
        chk("R10 no hold without retention", {31'h0, pin_hold}, 0);
        wr(12'h12C, 32'h1);
        rd(12'h12C, r); chk("R10 control readback", r, 1);
        chk("R10 flag", {31'h0, retain_flag}, 1);
        chk("R10 hold low while awake", {31'h0, pin_hold}, 0);
        sleep_i = 1'b1;
        #1;
        chk("R10 hold while asleep", {31'h0, pin_hold}, 1);
        wr(12'h12C, 32'h0);
        chk("R10 hold drops with retention", {30'h0, retain_flag, pin_hold}, 0);
        sleep_i = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule